// File: doc/BRIEF.md
# Block-Granular Security Filter for an SRAM Port

This block stands in the path from an AHB-style bus master to one SRAM bank. It divides the bank into equal blocks. A configuration input sets the block size to any power of two from 32 bytes upward. A bitmap input holds one security attribute bit per block. Every active transfer is compared with the attribute of the block it addresses, using the transfer's non-secure flag.

A transfer whose flag agrees with its block goes through to the memory unchanged, and the memory's response comes back to the master. A transfer that disagrees never reaches the memory. The filter answers it on its own, in one of two ways chosen by a mode input:

- **Silent mode:** a single OKAY cycle, with read data forced to zero.
- **Error mode:** the two-cycle AHB error response.

Each blocked transfer also produces a one-cycle violation report, intended for a separate capture unit. The report carries the full address, the master ID, the transfer's non-secure flag and the block attribute that was looked up.

Back-pressure follows AHB rules. The memory side stalls the master through its ready output, which the filter passes back whenever a forwarded transfer is in its data phase. The filter itself stalls the master for one cycle, and only during the first cycle of an error response. The violation report has no ready input: the capture unit must take every pulse in the cycle it appears.

Top module: `blk_sec_filter`

## Requirements
- R1: The block size is 32 << cfg_blk_size bytes. The block index of a transfer is address bits [11:5] shifted right by cfg_blk_size, so at size 0 addresses 0x01F and 0x020 lie in blocks 0 and 1, and at size 1 addresses 0x03F and 0x040 lie in blocks 0 and 1.
- R2: sec_map bit i is the attribute of block i, where 0 means Secure and 1 means Non-secure. A NONSEQ or SEQ transfer passes only when s_hnonsec equals that bit. Both mismatch directions block the transfer.
- R3: A passing transfer appears on the memory side with unchanged address, type (s_htrans 2 = NONSEQ), direction, attributes and write data. Its data phase returns the memory's ready, response and read data.
- R4: A blocked transfer is shown to the memory as IDLE (m_htrans = 0) with m_hwrite low, so the memory never performs a write for it.
- R5: With cfg_err_resp = 0, a blocked transfer gets one data-phase cycle with s_hreadyout = 1, s_hresp = 0 (OKAY) and s_hrdata = 0.
- R6: With cfg_err_resp = 1, a blocked transfer gets s_hresp = 1 with s_hreadyout = 0 in the first data-phase cycle, then s_hresp = 1 with s_hreadyout = 1 in the second.
- R7: IDLE (0) and BUSY (1) transfers are never checked. They are forwarded with their type, they raise no violation, and they receive OKAY.
- R8: viol_valid is high for exactly the one cycle after a blocked address phase is accepted (s_hready high). In that cycle viol_addr, viol_master and viol_nonsec hold that transfer's address, master ID and non-secure flag, and viol_blk_attr holds the looked-up block bit.
- R9: After reset, s_hreadyout = 1, s_hresp = 0 and viol_valid = 0.
- R10: The response mode used for a blocked transfer is the value of cfg_err_resp at its address phase. A later change does not alter an error response that has already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_blk_size | input | 4 | Block size exponent; size = 32 << value bytes |
| cfg_err_resp | input | 1 | Blocked-transfer reaction: 0 silent, 1 bus error |
| sec_map | input | 128 | Per-block attribute bits (0 Secure, 1 Non-secure) |
| s_haddr | input | 32 | Master address |
| s_htrans | input | 2 | Master transfer type |
| s_hwrite | input | 1 | Master write flag |
| s_hnonsec | input | 1 | Master non-secure attribute |
| s_hmaster | input | 16 | Master ID |
| s_hwdata | input | 32 | Master write data |
| s_hready | input | 1 | Bus ready seen by the master side |
| s_hreadyout | output | 1 | Ready returned to the master |
| s_hresp | output | 1 | Response to the master (1 = ERROR) |
| s_hrdata | output | 32 | Read data to the master |
| m_haddr | output | 32 | Memory-side address |
| m_htrans | output | 2 | Memory-side transfer type (IDLE when blocked) |
| m_hwrite | output | 1 | Memory-side write flag |
| m_hnonsec | output | 1 | Memory-side non-secure attribute |
| m_hmaster | output | 16 | Memory-side master ID |
| m_hwdata | output | 32 | Memory-side write data |
| m_hready | output | 1 | Bus ready passed to the memory |
| m_hreadyout | input | 1 | Memory ready |
| m_hresp | input | 1 | Memory response |
| m_hrdata | input | 32 | Memory read data |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_addr | output | 32 | Address of the blocked transfer |
| viol_master | output | 16 | Master ID of the blocked transfer |
| viol_nonsec | output | 1 | Non-secure flag of the blocked transfer |
| viol_blk_attr | output | 1 | Attribute bit of the addressed block |

## Verification
The hardest case to reach is a blocked transfer whose data phase overlaps the address phase of the next, permitted transfer. The filter's own answer to the blocked transfer and the forwarded memory request must both be correct in the same cycle. The bench creates this by presenting a passing read in the very cycle the silent answer is returned. It then checks that the read reaches the memory and receives the memory's data one cycle later.

A second hard case is a configuration change in the middle of an error response. The bench drops the mode input between the two error cycles and checks that the second cycle still carries the error.

// File: rtl/blk_sec_pkg.sv
package blk_sec_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int MID_W  = 16;
  localparam int BSZ_W  = 4;
  localparam int MIN_SHIFT = 5;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } htrans_e;

  typedef enum logic [1:0] {
    DP_FWD,
    DP_QUIET,
    DP_ERR_A,
    DP_ERR_B
  } dphase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [MID_W-1:0]  master;
    logic              nonsec;
    logic              blk_attr;
  } viol_t;
endpackage

// File: rtl/blk_sec_lookup.sv
module blk_sec_lookup
  import blk_sec_pkg::*;
#(
  parameter int IDX_W = 7,
  localparam int NBLK = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] addr_hi,
  input  logic [BSZ_W-1:0] blk_size,
  input  logic [NBLK-1:0]  map,
  output logic             blk_attr
);
  logic [IDX_W-1:0] idx;

  // address bits above the minimum block size, scaled by the size exponent
  always_comb begin
    idx      = addr_hi >> blk_size;
    blk_attr = map[idx];
  end
endmodule

// File: rtl/blk_sec_resp.sv
module blk_sec_resp
  import blk_sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ready,
  input  logic              accept,
  input  logic              blocked,
  input  logic              err_mode,
  input  logic              mem_ready,
  input  logic              mem_resp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              up_ready,
  output logic              up_resp,
  output logic [DATA_W-1:0] up_rdata
);
  dphase_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == DP_ERR_A) begin
      st_d = DP_ERR_B;
    end else if (bus_ready) begin
      if (accept && blocked) st_d = err_mode ? DP_ERR_A : DP_QUIET;
      else                   st_d = DP_FWD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DP_FWD;
    else        st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      DP_QUIET: begin up_ready = 1'b1; up_resp = 1'b0; up_rdata = '0; end
      DP_ERR_A: begin up_ready = 1'b0; up_resp = 1'b1; up_rdata = '0; end
      DP_ERR_B: begin up_ready = 1'b1; up_resp = 1'b1; up_rdata = '0; end
      default:  begin up_ready = mem_ready; up_resp = mem_resp; up_rdata = mem_rdata; end
    endcase
  end
endmodule

// File: rtl/blk_sec_report.sv
module blk_sec_report
  import blk_sec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  viol_t info_in,
  output logic  valid,
  output viol_t info_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      info_out <= '0;
    end else begin
      valid <= fire;
      if (fire) info_out <= info_in;
    end
  end
endmodule

// File: rtl/blk_sec_filter.sv
module blk_sec_filter
  import blk_sec_pkg::*;
#(
  parameter int MEM_AW = 12,
  localparam int IDX_W = MEM_AW - MIN_SHIFT,
  localparam int NBLK  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSZ_W-1:0]  cfg_blk_size,
  input  logic              cfg_err_resp,
  input  logic [NBLK-1:0]   sec_map,
  input  logic [ADDR_W-1:0] s_haddr,
  input  logic [1:0]        s_htrans,
  input  logic              s_hwrite,
  input  logic              s_hnonsec,
  input  logic [MID_W-1:0]  s_hmaster,
  input  logic [DATA_W-1:0] s_hwdata,
  input  logic              s_hready,
  output logic              s_hreadyout,
  output logic              s_hresp,
  output logic [DATA_W-1:0] s_hrdata,
  output logic [ADDR_W-1:0] m_haddr,
  output logic [1:0]        m_htrans,
  output logic              m_hwrite,
  output logic              m_hnonsec,
  output logic [MID_W-1:0]  m_hmaster,
  output logic [DATA_W-1:0] m_hwdata,
  output logic              m_hready,
  input  logic              m_hreadyout,
  input  logic              m_hresp,
  input  logic [DATA_W-1:0] m_hrdata,
  output logic              viol_valid,
  output logic [ADDR_W-1:0] viol_addr,
  output logic [MID_W-1:0]  viol_master,
  output logic              viol_nonsec,
  output logic              viol_blk_attr
);
  logic  blk_attr, active, block_now, accept;
  viol_t info_d, info_q;

  blk_sec_lookup #(.IDX_W(IDX_W)) u_lookup (
    .addr_hi  (s_haddr[MEM_AW-1:MIN_SHIFT]),
    .blk_size (cfg_blk_size),
    .map      (sec_map),
    .blk_attr (blk_attr)
  );

  // only NONSEQ and SEQ carry a real access
  assign active    = (s_htrans == TR_NONSEQ) || (s_htrans == TR_SEQ);
  assign block_now = active && (s_hnonsec != blk_attr);
  assign accept    = s_hready && active;

  assign m_haddr   = s_haddr;
  assign m_htrans  = block_now ? TR_IDLE : s_htrans;
  assign m_hwrite  = s_hwrite && !block_now;
  assign m_hnonsec = s_hnonsec;
  assign m_hmaster = s_hmaster;
  assign m_hwdata  = s_hwdata;
  assign m_hready  = s_hready;

  blk_sec_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ready (s_hready),
    .accept    (accept),
    .blocked   (block_now),
    .err_mode  (cfg_err_resp),
    .mem_ready (m_hreadyout),
    .mem_resp  (m_hresp),
    .mem_rdata (m_hrdata),
    .up_ready  (s_hreadyout),
    .up_resp   (s_hresp),
    .up_rdata  (s_hrdata)
  );

  assign info_d = '{addr: s_haddr, master: s_hmaster, nonsec: s_hnonsec, blk_attr: blk_attr};

  blk_sec_report u_report (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (accept && block_now),
    .info_in  (info_d),
    .valid    (viol_valid),
    .info_out (info_q)
  );

  assign viol_addr     = info_q.addr;
  assign viol_master   = info_q.master;
  assign viol_nonsec   = info_q.nonsec;
  assign viol_blk_attr = info_q.blk_attr;
endmodule

// File: rtl/blk_sec_filter_chk.sv
module blk_sec_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_hready,
  input logic [1:0]  s_htrans,
  input logic [31:0] s_haddr,
  input logic        s_hreadyout,
  input logic        s_hresp,
  input logic [31:0] s_hrdata,
  input logic [1:0]  m_htrans,
  input logic        m_hwrite,
  input logic        viol_valid,
  input logic [31:0] viol_addr
);
  // R4: a reported violation was never shown to memory as a real access
  a_r4_blocked_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(m_htrans) == 2'b00 && !$past(m_hwrite)));

  // R6: a stalled error cycle is always followed by the completing error cycle
  a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hresp && !s_hreadyout) |=> (s_hresp && s_hreadyout));

  // R6: a completing error cycle is always preceded by the stalled one
  a_r6_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hresp && s_hreadyout) |-> $past(s_hresp && !s_hreadyout));

  // R8: the pulse follows an accepted active address phase and carries its address
  a_r8_viol_source: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(s_hready && s_htrans[1]) && viol_addr == $past(s_haddr)));

  // R7: idle or busy address phases never raise a violation
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hready && !s_htrans[1]) |=> !viol_valid);

  // R5: a silent answer returns zero data with OKAY
  a_r5_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && s_hreadyout) |-> (s_hrdata == 32'd0 && !s_hresp));
endmodule

bind blk_sec_filter blk_sec_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_hready    (s_hready),
  .s_htrans    (s_htrans),
  .s_haddr     (s_haddr),
  .s_hreadyout (s_hreadyout),
  .s_hresp     (s_hresp),
  .s_hrdata    (s_hrdata),
  .m_htrans    (m_htrans),
  .m_hwrite    (m_hwrite),
  .viol_valid  (viol_valid),
  .viol_addr   (viol_addr)
);

// File: tb/blk_sec_filter_test.sv
module blk_sec_filter_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [3:0]   cfg_blk_size = '0;
  logic         cfg_err_resp = 1'b0;
  logic [127:0] sec_map = {64{2'b10}};
  logic [31:0]  s_haddr = '0;
  logic [1:0]   s_htrans = 2'b00;
  logic         s_hwrite = 1'b0;
  logic         s_hnonsec = 1'b0;
  logic [15:0]  s_hmaster = '0;
  logic [31:0]  s_hwdata = '0;
  logic         s_hready;
  logic         s_hreadyout, s_hresp;
  logic [31:0]  s_hrdata;
  logic [31:0]  m_haddr, m_hwdata, m_hrdata;
  logic [1:0]   m_htrans;
  logic         m_hwrite, m_hnonsec, m_hready;
  logic [15:0]  m_hmaster;
  logic         viol_valid, viol_nonsec, viol_blk_attr;
  logic [31:0]  viol_addr;
  logic [15:0]  viol_master;

  assign s_hready = s_hreadyout;

  blk_sec_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_blk_size(cfg_blk_size), .cfg_err_resp(cfg_err_resp),
    .sec_map(sec_map), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite),
    .s_hnonsec(s_hnonsec), .s_hmaster(s_hmaster), .s_hwdata(s_hwdata), .s_hready(s_hready),
    .s_hreadyout(s_hreadyout), .s_hresp(s_hresp), .s_hrdata(s_hrdata),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hnonsec(m_hnonsec),
    .m_hmaster(m_hmaster), .m_hwdata(m_hwdata), .m_hready(m_hready),
    .m_hreadyout(1'b1), .m_hresp(1'b0), .m_hrdata(m_hrdata),
    .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_master(viol_master),
    .viol_nonsec(viol_nonsec), .viol_blk_attr(viol_blk_attr)
  );

  // memory model: always ready, read data tagged with the data-phase address
  logic [31:0] dp_addr = '0;
  int wr_cnt = 0;
  logic [31:0] last_wr = '0;
  always_ff @(posedge clk) begin
    if (m_hready && m_htrans[1]) begin
      dp_addr <= m_haddr;
      if (m_hwrite) begin
        wr_cnt  <= wr_cnt + 1;
        last_wr <= m_haddr;
      end
    end
  end
  assign m_hrdata = {20'hA5A5A, dp_addr[11:0]};

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {addr[11:0], size[3:0], nonsec, write, errmode, expected block bit}
  localparam logic [19:0] VEC [13] = '{
    {12'h01F, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {12'h020, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'h020, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {12'h01F, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {12'h03F, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {12'h040, 4'd1, 1'b1, 1'b0, 1'b1, 1'b1},
    {12'h040, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    {12'h07F, 4'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    {12'h0C0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {12'hFFF, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1},
    {12'h080, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {12'h3FF, 4'd4, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'h1FF, 4'd4, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic xfer(input logic [11:0] a, input logic [3:0] bsz, input logic ns,
                      input logic wr, input logic em, input logic blk);
    logic blocked;
    int wc0;
    blocked = (ns != blk);
    @(negedge clk);
    cfg_blk_size = bsz;
    cfg_err_resp = em;
    s_haddr   = {20'h20000, a};
    s_htrans  = 2'b10;
    s_hwrite  = wr;
    s_hnonsec = ns;
    s_hmaster = {4'h7, a};
    wc0 = wr_cnt;
    #1;
    chk(blocked ? "R4 blocked shown idle" : "R3 forwarded type", {30'd0, m_htrans},
        blocked ? 32'd0 : 32'd2);
    chk("R1 R2 R3 address forwarded", m_haddr, {20'h20000, a});
    @(negedge clk);
    s_htrans = 2'b00;
    s_hwdata = {20'hD0D0D, a};
    chk("R8 violation pulse", {31'd0, viol_valid}, {31'd0, blocked});
    if (blocked) begin
      chk("R8 violation address", viol_addr, {20'h20000, a});
      chk("R8 violation master", {16'd0, viol_master}, {16'd0, 4'h7, a});
      chk("R8 violation attributes", {30'd0, viol_nonsec, viol_blk_attr}, {30'd0, ns, blk});
      chk("R4 no memory write", wr_cnt, wc0);
      if (!em) begin
        chk("R5 silent ready/resp", {30'd0, s_hreadyout, s_hresp}, 32'd2);
        chk("R5 silent zero data", s_hrdata, 32'd0);
      end else begin
        chk("R6 error cycle one", {30'd0, s_hreadyout, s_hresp}, 32'd1);
        @(negedge clk);
        chk("R6 error cycle two", {30'd0, s_hreadyout, s_hresp}, 32'd3);
        chk("R8 pulse lasts one cycle", {31'd0, viol_valid}, 32'd0);
      end
    end else begin
      chk("R3 forwarded ready/resp", {30'd0, s_hreadyout, s_hresp}, 32'd2);
      if (wr) begin
        chk("R3 write reached memory", wr_cnt, wc0 + 1);
        chk("R3 write address", last_wr, {20'h20000, a});
      end else begin
        chk("R3 read data returned", s_hrdata, {20'hA5A5A, a});
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 reset ready/resp", {30'd0, s_hreadyout, s_hresp}, 32'd2);
    chk("R9 reset no violation", {31'd0, viol_valid}, 32'd0);

    for (int i = 0; i < 13; i++) begin
      xfer(VEC[i][19:8], VEC[i][7:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R7: IDLE with mismatching attribute is not checked
    @(negedge clk);
    cfg_blk_size = 4'd0; cfg_err_resp = 1'b1;
    s_haddr = 32'h2000_0000; s_hnonsec = 1'b1; s_htrans = 2'b00; s_hwrite = 1'b1;
    #1 chk("R7 idle forwarded", {30'd0, m_htrans}, 32'd0);
    @(negedge clk);
    chk("R7 idle no violation", {31'd0, viol_valid}, 32'd0);
    chk("R7 idle okay", {30'd0, s_hreadyout, s_hresp}, 32'd2);
    // R7: BUSY is forwarded with its type
    s_htrans = 2'b01;
    #1 chk("R7 busy forwarded", {30'd0, m_htrans}, 32'd1);
    @(negedge clk);
    s_htrans = 2'b00; s_hwrite = 1'b0;
    chk("R7 busy no violation", {31'd0, viol_valid}, 32'd0);
    chk("R7 busy okay", {30'd0, s_hreadyout, s_hresp}, 32'd2);

    // pipelined: silent block, then a passing read in its data phase
    @(negedge clk);
    cfg_err_resp = 1'b0;
    s_haddr = 32'h2000_001F; s_hnonsec = 1'b1; s_htrans = 2'b10;
    @(negedge clk);
    chk("R5 pipelined silent zero", s_hrdata, 32'd0);
    chk("R8 pipelined pulse", {31'd0, viol_valid}, 32'd1);
    s_haddr = 32'h2000_0020;
    #1 chk("R3 pipelined read forwarded", {30'd0, m_htrans}, 32'd2);
    @(negedge clk);
    s_htrans = 2'b00;
    chk("R3 pipelined read data", s_hrdata, 32'hA5A5A020);
    chk("R2 pipelined no violation", {31'd0, viol_valid}, 32'd0);

    // R10: mode change during an error response
    @(negedge clk);
    cfg_err_resp = 1'b1;
    s_haddr = 32'h2000_0000; s_hnonsec = 1'b1; s_htrans = 2'b10;
    @(negedge clk);
    s_htrans = 2'b00;
    cfg_err_resp = 1'b0;
    chk("R10 error cycle one", {30'd0, s_hreadyout, s_hresp}, 32'd1);
    @(negedge clk);
    chk("R10 error cycle two kept", {30'd0, s_hreadyout, s_hresp}, 32'd3);
    @(negedge clk);
    chk("R10 back to okay", {30'd0, s_hreadyout, s_hresp}, 32'd2);

    finish_run();
  end
endmodule